// File: doc/BRIEF.md
# Multi-channel DMA channel engine

The block keeps the programming state of eight DMA channels and does the bookkeeping for each burst a device asks for. Software sets each channel up through a 32-bit register bus: a mode word (enable, direction, three status flags), a remaining byte count and a memory address. A device then presents a request made of a channel number, the direction it wants to move data in and the number of bytes it would like to move.

The engine takes one request at a time. It first clears the channel's three status flags. It then checks that the channel is enabled and that its programmed direction matches the request. A consistent request is granted the smaller of the requested length and the remaining count. The engine then issues a one-cycle command on the memory port, carrying the channel's address and the granted length, subtracts the grant from the count and raises the terminal-count flag. An inconsistent request moves nothing. It raises the channel's memory-error flag and latches a per-channel bit in a sticky non-maskable-interrupt source word. Moving the data and translating the address belong to other blocks.

Top module: `dma_chan_engine`

## Requirements
- R1: After reset every channel register and the interrupt source word read as zero, `req_ready` is 1 and `mem_valid` is 0.
- R2: The register of index k (1 = mode, 2 = count, 3 = address) of channel c sits at byte offset 0x100 + 0x20*c + 8*k. The index comes from offset bits [4:3] and bits [2:0] are ignored. Reads are combinational and return the full 32 bits written. Index 0 reads zero and ignores writes, and any unmapped offset reads zero.
- R3: `req_ready` is 1 while idle. A request accepted at a clock edge drives `req_ready` to 0 for exactly the following cycle. If the request is consistent, `mem_valid` is 1 during the cycle after that, for exactly one cycle. The updated mode and count are readable from that same cycle.
- R4: The memory command carries the channel number, the request direction, the channel's address register and a length equal to the smaller of the requested length and the count register.
- R5: A consistent request subtracts the granted length from the count (the count is never negative) and leaves mode bit 8 (terminal count) set and bits 9 and 10 clear. This holds for a zero grant too.
- R6: A request on a channel whose mode bit 0 (enable) is 0 issues no memory command and leaves the count unchanged. It leaves mode bit 9 (memory error) set and bits 8 and 10 clear, and sets bit c of the interrupt source word.
- R7: A request with `req_to_mem` = 1 (device to memory) needs mode bit 1 = 0. A request with `req_to_mem` = 0 (memory to device) needs mode bit 1 = 1. A mismatch has the same effect as R6.
- R8: The interrupt source word reads at offset 0x200 (offset bits [1:0] ignored) with bit c for channel c. Its bits only ever get set, and bus writes to it are ignored.
- R9: A request changes no mode bit other than 8, 9 and 10, and never changes the address register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 10 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| req_valid | input | 1 | Device request present |
| req_ready | output | 1 | Engine can accept a request |
| req_ch | input | 3 | Requesting channel |
| req_to_mem | input | 1 | 1: device to memory, 0: memory to device |
| req_len | input | 32 | Requested length |
| mem_valid | output | 1 | One-cycle memory command |
| mem_ch | output | 3 | Channel of the command |
| mem_to_mem | output | 1 | Direction of the command |
| mem_addr | output | 32 | Memory address of the command |
| mem_len | output | 32 | Granted length |

## Verification
A wrong count or a wrong flag shows up on the register bus in the same cycle as the memory command that caused it. It also shows up one burst later as a wrong grant, because the next request is clamped against the stale count. A consistency check that goes the wrong way shows up at once as a memory command where none was due, or as an interrupt source bit, and that bit stays set for the rest of the run. Random mode words with the flag bits and high bits set pick up flag clearing that is missing or that reaches too many bits. Zero counts and zero lengths exercise the clamp at its lower edge.

// File: rtl/dma_pkg.sv
`timescale 1ns/1ps
package dma_pkg;
  // bit positions inside a channel mode word
  localparam int unsigned MODE_EN_BIT   = 0;
  localparam int unsigned MODE_M2D_BIT  = 1;
  localparam int unsigned MODE_TC_BIT   = 8;
  localparam int unsigned MODE_MERR_BIT = 9;
  localparam int unsigned MODE_AERR_BIT = 10;

  // register index inside a channel window, from offset bits [4:3]
  typedef enum logic [1:0] {
    IDX_RSV   = 2'd0,
    IDX_MODE  = 2'd1,
    IDX_COUNT = 2'd2,
    IDX_ADDR  = 2'd3
  } reg_idx_e;

  typedef enum logic {
    CS_IDLE = 1'b0,
    CS_EXEC = 1'b1
  } ctrl_state_e;
endpackage

// File: rtl/dma_regfile.sv
`timescale 1ns/1ps
module dma_regfile
  import dma_pkg::*;
#(
  parameter int unsigned NCH = 8,
  parameter int unsigned DW  = 32,
  parameter int unsigned CHW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_en,
  input  logic [CHW-1:0]           wr_ch,
  input  reg_idx_e                 wr_idx,
  input  logic [DW-1:0]            wr_data,
  input  logic                     upd_en,
  input  logic [CHW-1:0]           upd_ch,
  input  logic [DW-1:0]            upd_mode,
  input  logic                     upd_cnt_en,
  input  logic [DW-1:0]            upd_count,
  input  logic                     nmi_set_en,
  output logic [NCH-1:0][DW-1:0]   mode_o,
  output logic [NCH-1:0][DW-1:0]   count_o,
  output logic [NCH-1:0][DW-1:0]   addr_o,
  output logic [NCH-1:0]           nmi_o
);

  logic [NCH-1:0] nmi_q, nmi_d;

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    logic [DW-1:0] mode_q, mode_d, cnt_q, cnt_d, adr_q, adr_d;
    logic          bus_sel, eng_sel;

    assign bus_sel = wr_en  && (wr_ch  == CHW'(i));
    assign eng_sel = upd_en && (upd_ch == CHW'(i));

    // engine update has priority over a bus write in the same cycle
    always_comb begin
      mode_d = mode_q;
      cnt_d  = cnt_q;
      adr_d  = adr_q;
      if (bus_sel && wr_idx == IDX_MODE)  mode_d = wr_data;
      if (bus_sel && wr_idx == IDX_COUNT) cnt_d  = wr_data;
      if (bus_sel && wr_idx == IDX_ADDR)  adr_d  = wr_data;
      if (eng_sel)               mode_d = upd_mode;
      if (eng_sel && upd_cnt_en) cnt_d  = upd_count;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        mode_q <= '0;
        cnt_q  <= '0;
        adr_q  <= '0;
      end else if (bus_sel || eng_sel) begin
        mode_q <= mode_d;
        cnt_q  <= cnt_d;
        adr_q  <= adr_d;
      end
    end

    assign mode_o[i]  = mode_q;
    assign count_o[i] = cnt_q;
    assign addr_o[i]  = adr_q;
  end

  always_comb begin
    nmi_d = nmi_q;
    if (nmi_set_en) nmi_d[upd_ch] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          nmi_q <= '0;
    else if (nmi_set_en) nmi_q <= nmi_d;
  end

  assign nmi_o = nmi_q;

  // R8: interrupt source bits are sticky
  a_r8_nmi_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((~nmi_q & $past(nmi_q)) == '0));

  // R5: an engine count update never raises the count
  a_r5_count_never_grows: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_en && upd_cnt_en) |=> (count_o[$past(upd_ch)] <= $past(count_o[upd_ch])));

endmodule

// File: rtl/dma_req_ctrl.sv
`timescale 1ns/1ps
module dma_req_ctrl
  import dma_pkg::*;
#(
  parameter int unsigned NCH = 8,
  parameter int unsigned DW  = 32,
  parameter int unsigned CHW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     req_valid,
  output logic                     req_ready,
  input  logic [CHW-1:0]           req_ch,
  input  logic                     req_to_mem,
  input  logic [DW-1:0]            req_len,
  input  logic [NCH-1:0][DW-1:0]   mode_i,
  input  logic [NCH-1:0][DW-1:0]   count_i,
  input  logic [NCH-1:0][DW-1:0]   addr_i,
  output logic                     upd_en,
  output logic [CHW-1:0]           upd_ch,
  output logic [DW-1:0]            upd_mode,
  output logic                     upd_cnt_en,
  output logic [DW-1:0]            upd_count,
  output logic                     nmi_set_en,
  output logic                     mem_valid,
  output logic [CHW-1:0]           mem_ch,
  output logic                     mem_to_mem,
  output logic [DW-1:0]            mem_addr,
  output logic [DW-1:0]            mem_len
);

  localparam logic [DW-1:0] BIT_TC   = DW'(1) << MODE_TC_BIT;
  localparam logic [DW-1:0] BIT_MERR = DW'(1) << MODE_MERR_BIT;
  localparam logic [DW-1:0] FLAGS    = BIT_TC | BIT_MERR | (DW'(1) << MODE_AERR_BIT);

  ctrl_state_e     st_q, st_d;
  logic [CHW-1:0]  ch_q;
  logic            dir_q;
  logic [DW-1:0]   len_q;
  logic            accept, consistent;
  logic [DW-1:0]   cur_mode, cur_cnt, grant;
  logic            mv_q;
  logic [CHW-1:0]  mch_q;
  logic            mdir_q;
  logic [DW-1:0]   madr_q, mlen_q;

  assign req_ready = (st_q == CS_IDLE);
  assign accept    = req_valid && req_ready;

  always_comb begin
    st_d = st_q;
    if (accept)              st_d = CS_EXEC;
    else if (st_q == CS_EXEC) st_d = CS_IDLE;
  end

  assign cur_mode   = mode_i[ch_q];
  assign cur_cnt    = count_i[ch_q];
  assign consistent = cur_mode[MODE_EN_BIT] && (dir_q != cur_mode[MODE_M2D_BIT]);
  assign grant      = (len_q < cur_cnt) ? len_q : cur_cnt;

  assign upd_en     = (st_q == CS_EXEC);
  assign upd_ch     = ch_q;
  assign upd_mode   = (cur_mode & ~FLAGS) | (consistent ? BIT_TC : BIT_MERR);
  assign upd_cnt_en = upd_en && consistent;
  assign upd_count  = cur_cnt - grant;
  assign nmi_set_en = upd_en && !consistent;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= CS_IDLE;
    else        st_q <= st_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ch_q  <= '0;
      dir_q <= 1'b0;
      len_q <= '0;
    end else if (accept) begin
      ch_q  <= req_ch;
      dir_q <= req_to_mem;
      len_q <= req_len;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mv_q <= 1'b0;
    else        mv_q <= upd_cnt_en;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mch_q  <= '0;
      mdir_q <= 1'b0;
      madr_q <= '0;
      mlen_q <= '0;
    end else if (upd_cnt_en) begin
      mch_q  <= ch_q;
      mdir_q <= dir_q;
      madr_q <= addr_i[ch_q];
      mlen_q <= grant;
    end
  end

  assign mem_valid  = mv_q;
  assign mem_ch     = mch_q;
  assign mem_to_mem = mdir_q;
  assign mem_addr   = madr_q;
  assign mem_len    = mlen_q;

  // R3: an accepted request blocks the next cycle
  a_r3_ready_drops: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !req_ready);

  // R3: a memory command lasts one cycle
  a_r3_cmd_single: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid |=> !mem_valid);

  // R4: the grant never exceeds the request
  a_r4_grant_bound: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid |-> (mem_len <= len_q));

endmodule

// File: rtl/dma_chan_engine.sv
`timescale 1ns/1ps
module dma_chan_engine
  import dma_pkg::*;
#(
  parameter int unsigned NCH = 8,
  parameter int unsigned DW  = 32,
  parameter int unsigned AW  = 10,
  parameter int unsigned CHW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            reg_we,
  input  logic [AW-1:0]   reg_addr,
  input  logic [DW-1:0]   reg_wdata,
  output logic [DW-1:0]   reg_rdata,
  input  logic            req_valid,
  output logic            req_ready,
  input  logic [CHW-1:0]  req_ch,
  input  logic            req_to_mem,
  input  logic [DW-1:0]   req_len,
  output logic            mem_valid,
  output logic [CHW-1:0]  mem_ch,
  output logic            mem_to_mem,
  output logic [DW-1:0]   mem_addr,
  output logic [DW-1:0]   mem_len
);

  localparam int unsigned  WIN_LOG2 = 5;
  localparam logic [AW-1:0] CH_BASE = AW'(32'h100);
  localparam logic [AW-1:0] CH_END  = AW'(32'h100 + NCH * (1 << WIN_LOG2));
  localparam logic [AW-1:0] NMI_OFF = AW'(32'h200);

  logic [1:0] rst_pipe;
  logic       rst_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_s = rst_pipe[1];

  logic                   chan_hit, nmi_hit;
  logic [CHW-1:0]         sel_ch;
  reg_idx_e               sel_idx;
  logic [NCH-1:0][DW-1:0] mode_w, count_w, addr_w;
  logic [NCH-1:0]         nmi_w;
  logic                   upd_en, upd_cnt_en, nmi_set_en;
  logic [CHW-1:0]         upd_ch;
  logic [DW-1:0]          upd_mode, upd_count;

  assign chan_hit = (reg_addr >= CH_BASE) && (reg_addr < CH_END);
  assign nmi_hit  = (reg_addr[AW-1:2] == NMI_OFF[AW-1:2]);
  assign sel_ch   = reg_addr[WIN_LOG2 +: CHW];
  assign sel_idx  = reg_idx_e'(reg_addr[4:3]);

  always_comb begin
    reg_rdata = '0;
    if (chan_hit) begin
      unique case (sel_idx)
        IDX_MODE:  reg_rdata = mode_w[sel_ch];
        IDX_COUNT: reg_rdata = count_w[sel_ch];
        IDX_ADDR:  reg_rdata = addr_w[sel_ch];
        default:   reg_rdata = '0;
      endcase
    end else if (nmi_hit) begin
      reg_rdata = DW'(nmi_w);
    end
  end

  dma_regfile #(.NCH(NCH), .DW(DW), .CHW(CHW)) u_regs (
    .clk        (clk),
    .rst_n      (rst_s),
    .wr_en      (reg_we && chan_hit),
    .wr_ch      (sel_ch),
    .wr_idx     (sel_idx),
    .wr_data    (reg_wdata),
    .upd_en     (upd_en),
    .upd_ch     (upd_ch),
    .upd_mode   (upd_mode),
    .upd_cnt_en (upd_cnt_en),
    .upd_count  (upd_count),
    .nmi_set_en (nmi_set_en),
    .mode_o     (mode_w),
    .count_o    (count_w),
    .addr_o     (addr_w),
    .nmi_o      (nmi_w)
  );

  dma_req_ctrl #(.NCH(NCH), .DW(DW), .CHW(CHW)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_s),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .req_ch     (req_ch),
    .req_to_mem (req_to_mem),
    .req_len    (req_len),
    .mode_i     (mode_w),
    .count_i    (count_w),
    .addr_i     (addr_w),
    .upd_en     (upd_en),
    .upd_ch     (upd_ch),
    .upd_mode   (upd_mode),
    .upd_cnt_en (upd_cnt_en),
    .upd_count  (upd_count),
    .nmi_set_en (nmi_set_en),
    .mem_valid  (mem_valid),
    .mem_ch     (mem_ch),
    .mem_to_mem (mem_to_mem),
    .mem_addr   (mem_addr),
    .mem_len    (mem_len)
  );

  // R6: a newly raised interrupt source bit never comes with a command
  a_r6_fault_no_cmd: assert property (@(posedge clk) disable iff (!rst_s)
    (nmi_w != $past(nmi_w)) |-> !mem_valid);

  // R9: the address register is never moved by the request engine
  a_r9_addr_kept: assert property (@(posedge clk) disable iff (!rst_s)
    !$past(reg_we) |-> (addr_w == $past(addr_w)));

endmodule

// File: tb/sim_dma_chan_engine.sv
`timescale 1ns/1ps
module sim_dma_chan_engine;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        reg_we;
  logic [9:0]  reg_addr;
  logic [31:0] reg_wdata, reg_rdata;
  logic        req_valid, req_ready, req_to_mem;
  logic [2:0]  req_ch;
  logic [31:0] req_len;
  logic        mem_valid, mem_to_mem;
  logic [2:0]  mem_ch;
  logic [31:0] mem_addr, mem_len;

  always #5 clk = ~clk;

  dma_chan_engine u0 (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .req_valid(req_valid),
    .req_ready(req_ready), .req_ch(req_ch), .req_to_mem(req_to_mem),
    .req_len(req_len), .mem_valid(mem_valid), .mem_ch(mem_ch),
    .mem_to_mem(mem_to_mem), .mem_addr(mem_addr), .mem_len(mem_len)
  );

  int unsigned n_chk = 0, n_bad = 0;
  logic [31:0] m_mode [8];
  logic [31:0] m_cnt  [8];
  logic [31:0] m_adr  [8];
  logic [7:0]  m_nmi;

  task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  function automatic logic [9:0] offs(input int ch, input int idx);
    return 10'(32'h100 + ch * 32 + idx * 8);
  endfunction

  function automatic logic [31:0] min32(input logic [31:0] a, input logic [31:0] b);
    return (a < b) ? a : b;
  endfunction

  task automatic wr(input logic [9:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [9:0] a, input logic [31:0] exp, input string rq);
    reg_addr = a;
    #1;
    chk(rq, reg_rdata, exp);
  endtask

  task automatic setup(input int ch, input logic [31:0] md, input logic [31:0] cn,
                       input logic [31:0] ad);
    wr(offs(ch, 1), md); m_mode[ch] = md;
    wr(offs(ch, 2), cn); m_cnt[ch]  = cn;
    wr(offs(ch, 3), ad); m_adr[ch]  = ad;
  endtask

  task automatic do_req(input int ch, input logic dir, input logic [31:0] len);
    logic        ok;
    logic [31:0] g;
    ok = m_mode[ch][0] && (dir == !m_mode[ch][1]);
    g  = min32(len, m_cnt[ch]);
    @(negedge clk);
    chk("R3 ready idle", 32'(req_ready), 32'd1);
    req_valid = 1'b1; req_ch = 3'(ch); req_to_mem = dir; req_len = len;
    @(negedge clk);
    req_valid = 1'b0;
    chk("R3 ready busy", 32'(req_ready), 32'd0);
    chk("R3 no early cmd", 32'(mem_valid), 32'd0);
    m_mode[ch] = (m_mode[ch] & ~32'h700) | (ok ? 32'h100 : 32'h200);
    if (ok) m_cnt[ch] = m_cnt[ch] - g;
    else    m_nmi[ch] = 1'b1;
    @(negedge clk);
    if (ok) begin
      chk("R3 cmd valid", 32'(mem_valid), 32'd1);
      chk("R4 cmd ch", 32'(mem_ch), 32'(ch));
      chk("R4 cmd dir", 32'(mem_to_mem), 32'(dir));
      chk("R4 cmd addr", mem_addr, m_adr[ch]);
      chk("R4 cmd len", mem_len, g);
    end else begin
      chk("R6 R7 no cmd on fault", 32'(mem_valid), 32'd0);
    end
    chk("R3 ready back", 32'(req_ready), 32'd1);
    rd(offs(ch, 1), m_mode[ch], "R5 R6 R9 mode after request");
    rd(offs(ch, 2), m_cnt[ch], "R5 count after request");
    rd(offs(ch, 3), m_adr[ch], "R9 address kept");
    rd(10'h200, 32'(m_nmi), "R8 interrupt source");
    @(negedge clk);
    chk("R3 cmd one cycle", 32'(mem_valid), 32'd0);
  endtask

  task automatic finish_run;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  endtask

  initial begin
    #1_500_000;
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    int unsigned seed;
    seed = $urandom(32'd1357);
    rst_n = 1'b0; reg_we = 1'b0; reg_addr = '0; reg_wdata = '0;
    req_valid = 1'b0; req_ch = '0; req_to_mem = 1'b0; req_len = '0;
    for (int i = 0; i < 8; i++) begin
      m_mode[i] = '0; m_cnt[i] = '0; m_adr[i] = '0;
    end
    m_nmi = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    chk("R1 ready after reset", 32'(req_ready), 32'd1);
    chk("R1 no cmd after reset", 32'(mem_valid), 32'd0);
    for (int c = 0; c < 8; c++)
      for (int k = 1; k < 4; k++)
        rd(offs(c, k), 32'd0, "R1 channel register zero");
    rd(10'h200, 32'd0, "R1 interrupt source zero");

    // R2 map, readback, ignored low bits, reserved index, unmapped
    setup(6, 32'h1234_5601, 32'hCAFE_0000, 32'hDEAD_BEEF);
    rd(offs(6, 1), 32'h1234_5601, "R2 mode readback");
    rd(offs(6, 2) + 10'd5, 32'hCAFE_0000, "R2 low offset bits ignored");
    rd(offs(6, 3), 32'hDEAD_BEEF, "R2 address readback");
    wr(offs(1, 0), 32'hFFFF_FFFF);
    rd(offs(1, 0), 32'd0, "R2 reserved index reads zero");
    rd(offs(1, 1), 32'd0, "R2 reserved write did not hit mode");
    rd(offs(1, 2), 32'd0, "R2 reserved write did not hit count");
    rd(10'h0F8, 32'd0, "R2 unmapped offset reads zero");
    setup(6, 32'd0, 32'd0, 32'd0);

    // R4 R5 clamp and countdown
    setup(0, 32'h0000_0001, 32'd10, 32'h0000_1000);
    do_req(0, 1'b1, 32'd4);
    do_req(0, 1'b1, 32'd20);
    do_req(0, 1'b1, 32'd5);   // zero count, zero grant
    setup(4, 32'h0000_0603, 32'd7, 32'h0040_0000);
    do_req(4, 1'b0, 32'd0);   // zero length request
    // R6 disabled channel
    setup(3, 32'h0000_0000, 32'd50, 32'h0000_3000);
    do_req(3, 1'b1, 32'd8);
    // R7 direction mismatch both ways
    setup(5, 32'h0000_0003, 32'd40, 32'h0000_5000);
    do_req(5, 1'b1, 32'd8);
    do_req(5, 1'b0, 32'd8);
    setup(7, 32'h0000_0001, 32'd40, 32'h0000_7000);
    do_req(7, 1'b0, 32'd8);
    // R9 high bits and flag bits in the mode word
    setup(2, 32'hFFFF_0701, 32'd100, 32'h0000_2000);
    do_req(2, 1'b1, 32'd33);
    // R8 writes to the interrupt source are ignored
    wr(10'h200, 32'h0000_0000);
    rd(10'h200, 32'(m_nmi), "R8 write ignored");
    wr(10'h203, 32'hFFFF_FFFF);
    rd(10'h201, 32'(m_nmi), "R8 write ignored, low bits");

    // random mix
    for (int it = 0; it < 400; it++) begin
      int ch;
      ch = int'($urandom_range(7, 0));
      if ($urandom_range(3, 0) == 0) begin
        logic [31:0] md;
        md = $urandom();
        md[0] = ($urandom_range(3, 0) != 0);
        setup(ch, md, 32'($urandom_range(80, 0)), $urandom());
      end
      do_req(ch, 1'($urandom_range(1, 0)), 32'($urandom_range(40, 0)));
    end

    for (int c = 0; c < 8; c++) begin
      rd(offs(c, 1), m_mode[c], "R9 final mode");
      rd(offs(c, 2), m_cnt[c], "R5 final count");
      rd(offs(c, 3), m_adr[c], "R2 final address");
    end
    rd(10'h200, 32'(m_nmi), "R8 final interrupt source");
    finish_run();
  end
endmodule